// File: doc/BRIEF.md
# UART Receive Byte Queue with Trigger Level and Idle Timeout

This block holds received characters for a UART until software fetches them through a register read. Bytes come from one of two sources, picked by a channel-mode input. One source is the line deserialiser, which also signals a detected line break. The other is the transmit-data register, used in local loopback. The queue is sixteen bytes deep by default. It keeps a fill count apart from its write and read pointers.

The status outputs are empty, full and a trigger flag set against a programmable fill threshold. A one-cycle overrun pulse marks a byte dropped for lack of room. A one-cycle timeout pulse marks that a set number of character times went by with no new byte stored. The character-time strobe comes from the baud logic outside the block. A pair of enable and disable inputs gates both ports. A clear input empties the queue at any time.

Top module: `rxq_fifo`

## Requirements
- R1: Bytes stored in the queue are returned by reads in the order they were stored. Up to DEPTH (16) bytes are held at once.
- R2: A byte offered while the queue holds DEPTH bytes is discarded and the stored contents do not change. `overrun` is high for exactly the one cycle after that offer.
- R3: `rx_empty` is 1 exactly when the queue holds no bytes, including straight after reset. `rx_full` is 1 exactly when it holds DEPTH bytes, so a single read clears it.
- R4: A read while the queue is empty returns 0x00 on `rd_data` and leaves `rx_empty` at 1.
- R5: After a stored byte, `rx_trigger` goes to 1 if the new count is at least the trigger level. After a read, it goes to 0 if the new count is below the trigger level. The trigger level resets to 32 and is loaded from `trig_value` when `trig_wr` is 1. With the reset level and a depth of 16, `rx_trigger` stays 0.
- R6: Offers and reads take effect only while `rx_enable` is 1 and `rx_disable` is 0. Otherwise the count is unchanged and `rd_data` reads 0x00.
- R7: Each stored byte restarts an idle count of `char_tick` pulses. The TMO_CHARS-th (4th) pulse with no stored byte in between drives `rx_timeout` high for one cycle. No further pulse follows until another byte is stored.
- R8: A cycle with `rx_clear` at 1 empties the queue. After it, `rx_empty` is 1, `rx_full` is 0 and `rx_trigger` is 0, and the idle count is stopped.
- R9: A `line_break` strobe from the line stores the byte 0x00, whatever `line_data` holds.
- R10: `chan_mode` picks the source. Values 0 (normal) and 1 (echo) take line bytes, value 2 (local loopback) takes `loop_valid`/`loop_data`, and value 3 (remote loopback) stores nothing. In every mode, the source that is not selected is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_enable | input | 1 | Receive enable |
| rx_disable | input | 1 | Receive disable; overrides enable |
| rx_clear | input | 1 | Empty the queue this cycle |
| chan_mode | input | 2 | Source select: 0 normal, 1 echo, 2 local loopback, 3 remote loopback |
| line_valid | input | 1 | Line byte strobe |
| line_break | input | 1 | Line break strobe, stored as 0x00 |
| line_data | input | 8 | Line byte |
| loop_valid | input | 1 | Transmit-register write strobe |
| loop_data | input | 8 | Transmit-register byte |
| rd_req | input | 1 | Register read of the data port |
| rd_data | output | 8 | Head byte when a read takes effect, else 0x00 |
| trig_wr | input | 1 | Load trigger level |
| trig_value | input | LVL_W (6) | New trigger level |
| char_tick | input | 1 | One pulse per character time |
| rx_empty | output | 1 | Queue holds no bytes |
| rx_full | output | 1 | Queue holds DEPTH bytes |
| rx_trigger | output | 1 | Fill level reached the trigger level |
| overrun | output | 1 | One-cycle pulse: byte dropped |
| rx_timeout | output | 1 | One-cycle pulse: idle timeout |

## Verification
The bench builds the block with its defaults: a depth of 16, a four-character timeout, a 6-bit trigger level and a reset level of 32. The depth of 16 lets the bench fill the queue within a few dozen cycles. Overrun, the full flag and pointer wrap-around all become reachable that way. The reset level above the depth shows that the trigger flag stays silent until software lowers the level. The short timeout lets the restart-by-write case and the single-pulse rule be shown with a handful of ticks.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;
    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        MODE_NORMAL      = 2'd0,
        MODE_ECHO        = 2'd1,
        MODE_LOCAL_LOOP  = 2'd2,
        MODE_REMOTE_LOOP = 2'd3
    } chan_mode_e;

    typedef struct packed {
        logic  valid;
        byte_t data;
    } beat_t;

    // Line bytes land in the queue in normal and echo modes.
    function automatic logic line_feeds(chan_mode_e m);
        return (m == MODE_NORMAL) || (m == MODE_ECHO);
    endfunction

    // Transmit-register bytes land in the queue only in local loopback.
    function automatic logic loop_feeds(chan_mode_e m);
        return m == MODE_LOCAL_LOOP;
    endfunction
endpackage

// File: rtl/rxq_source_sel.sv
`timescale 1ns/1ps
module rxq_source_sel
    import rxq_pkg::*;
(
    input  chan_mode_e mode,
    input  logic       line_valid,
    input  logic       line_break,
    input  byte_t      line_data,
    input  logic       loop_valid,
    input  byte_t      loop_data,
    output beat_t      beat
);
    always_comb begin
        beat = '0;
        if (line_feeds(mode) && (line_valid || line_break)) begin
            beat.valid = 1'b1;
            beat.data  = line_break ? '0 : line_data;   // R9: break is a zero byte
        end else if (loop_feeds(mode) && loop_valid) begin
            beat.valid = 1'b1;
            beat.data  = loop_data;
        end
    end
endmodule

// File: rtl/rxq_store.sv
`timescale 1ns/1ps
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             wr_req,
    input  byte_t            wr_data,
    input  logic             rd_req,
    output byte_t            head,
    output logic [CNT_W-1:0] count,
    output logic             pushed,
    output logic             popped,
    output logic             overrun
);
    byte_t            mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic             at_full;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign at_full = (count == CNT_W'(DEPTH));
    assign pushed  = wr_req && !at_full;
    assign popped  = rd_req && (count != '0);
    assign head    = mem[rptr];

    always_ff @(posedge clk) begin
        if (pushed && !clr) mem[wptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr    <= '0;
            rptr    <= '0;
            count   <= '0;
            overrun <= 1'b0;
        end else begin
            if (pushed) wptr <= bump(wptr);
            if (popped) rptr <= bump(rptr);
            count   <= count + CNT_W'(pushed) - CNT_W'(popped);
            overrun <= wr_req && at_full;
        end
    end

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));
    assert_overrun_cause_R2: assert property (@(posedge clk) disable iff (rst)
        overrun |-> ($past(count) == CNT_W'(DEPTH)));
    assert_full_holds_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_req && at_full && !rd_req && !clr) |=> (count == CNT_W'(DEPTH)));
endmodule

// File: rtl/rxq_timeout.sv
`timescale 1ns/1ps
module rxq_timeout #(
    parameter int TMO_CHARS = 4,
    localparam int TW = $clog2(TMO_CHARS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic restart,
    input  logic tick,
    output logic timeout
);
    logic          armed;
    logic [TW-1:0] ticks;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            armed   <= 1'b0;
            ticks   <= '0;
            timeout <= 1'b0;
        end else begin
            timeout <= 1'b0;
            if (restart) begin
                armed <= 1'b1;
                ticks <= '0;
            end else if (armed && tick) begin
                if (ticks == TW'(TMO_CHARS - 1)) begin
                    armed   <= 1'b0;
                    ticks   <= '0;
                    timeout <= 1'b1;
                end else begin
                    ticks <= ticks + 1'b1;
                end
            end
        end
    end

    assert_tmo_single_R7: assert property (@(posedge clk) disable iff (rst)
        timeout |=> !timeout);
    assert_tmo_on_tick_R7: assert property (@(posedge clk) disable iff (rst)
        timeout |-> ($past(tick) && !$past(restart)));
endmodule

// File: rtl/rxq_fifo.sv
`timescale 1ns/1ps
module rxq_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int TMO_CHARS  = 4,
    parameter int LVL_W      = 6,
    parameter int TRIG_RESET = 32,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int CMP_W = (LVL_W > CNT_W) ? LVL_W : CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_enable,
    input  logic             rx_disable,
    input  logic             rx_clear,
    input  logic [1:0]       chan_mode,
    input  logic             line_valid,
    input  logic             line_break,
    input  logic [7:0]       line_data,
    input  logic             loop_valid,
    input  logic [7:0]       loop_data,
    input  logic             rd_req,
    output logic [7:0]       rd_data,
    input  logic             trig_wr,
    input  logic [LVL_W-1:0] trig_value,
    input  logic             char_tick,
    output logic             rx_empty,
    output logic             rx_full,
    output logic             rx_trigger,
    output logic             overrun,
    output logic             rx_timeout
);
    logic             en, rd_fire, pushed, popped;
    beat_t            beat;
    byte_t            head;
    logic [CNT_W-1:0] count, cnt_nxt;
    logic [LVL_W-1:0] trig_q;

    assign en      = rx_enable && !rx_disable;   // R6
    assign rd_fire = en && rd_req;

    rxq_source_sel u_src (
        .mode       (chan_mode_e'(chan_mode)),
        .line_valid (line_valid),
        .line_break (line_break),
        .line_data  (line_data),
        .loop_valid (loop_valid),
        .loop_data  (loop_data),
        .beat       (beat)
    );

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .clr     (rx_clear),
        .wr_req  (en && beat.valid),
        .wr_data (beat.data),
        .rd_req  (rd_fire),
        .head    (head),
        .count   (count),
        .pushed  (pushed),
        .popped  (popped),
        .overrun (overrun)
    );

    rxq_timeout #(.TMO_CHARS(TMO_CHARS)) u_tmo (
        .clk     (clk),
        .rst     (rst),
        .clr     (rx_clear),
        .restart (pushed),
        .tick    (char_tick),
        .timeout (rx_timeout)
    );

    assign cnt_nxt  = count + CNT_W'(pushed) - CNT_W'(popped);
    assign rd_data  = popped ? head : '0;        // R4: zero on empty read
    assign rx_empty = (count == '0);
    assign rx_full  = (count == CNT_W'(DEPTH));

    // Trigger flag is evaluated only on queue events, against the level in force.
    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q     <= LVL_W'(TRIG_RESET);
            rx_trigger <= 1'b0;
        end else begin
            if (trig_wr) trig_q <= trig_value;
            if (rx_clear)
                rx_trigger <= 1'b0;
            else if (pushed && (CMP_W'(cnt_nxt) >= CMP_W'(trig_q)))
                rx_trigger <= 1'b1;
            else if (popped && (CMP_W'(cnt_nxt) < CMP_W'(trig_q)))
                rx_trigger <= 1'b0;
        end
    end

    assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        !(rx_full && rx_empty));
    assert_empty_read_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_fire && rx_empty) |-> (rd_data == 8'h00));
    assert_trigger_set_R5: assert property (@(posedge clk) disable iff (rst)
        (pushed && !rx_clear && (CMP_W'(cnt_nxt) >= CMP_W'(trig_q))) |=> rx_trigger);
    assert_gated_R6: assert property (@(posedge clk) disable iff (rst)
        (!en && !rx_clear) |=> (count == $past(count)));
    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
        rx_clear |=> (rx_empty && !rx_full && !rx_trigger));
endmodule

// File: tb/rxq_fifo_tb_top.sv
`timescale 1ns/1ps
module rxq_fifo_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_enable = 1'b1, rx_disable = 1'b0, rx_clear = 1'b0;
    logic [1:0] chan_mode = 2'd0;
    logic       line_valid = 1'b0, line_break = 1'b0, loop_valid = 1'b0;
    logic [7:0] line_data = 8'h00, loop_data = 8'h00;
    logic       rd_req = 1'b0, trig_wr = 1'b0, char_tick = 1'b0;
    logic [5:0] trig_value = 6'd0;
    logic [7:0] rd_data;
    logic       rx_empty, rx_full, rx_trigger, overrun, rx_timeout;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    rxq_fifo dut_i (
        .clk(clk), .rst(rst), .rx_enable(rx_enable), .rx_disable(rx_disable),
        .rx_clear(rx_clear), .chan_mode(chan_mode), .line_valid(line_valid),
        .line_break(line_break), .line_data(line_data), .loop_valid(loop_valid),
        .loop_data(loop_data), .rd_req(rd_req), .rd_data(rd_data),
        .trig_wr(trig_wr), .trig_value(trig_value), .char_tick(char_tick),
        .rx_empty(rx_empty), .rx_full(rx_full), .rx_trigger(rx_trigger),
        .overrun(overrun), .rx_timeout(rx_timeout)
    );

    // Stimulus table: {op, byte}; op 0 stores a line byte, op 1 reads expecting the byte.
    localparam logic [8:0] VEC [10] = '{
        {1'b0, 8'h11}, {1'b0, 8'h22}, {1'b0, 8'h33}, {1'b1, 8'h11}, {1'b0, 8'h44},
        {1'b1, 8'h22}, {1'b1, 8'h33}, {1'b1, 8'h44}, {1'b0, 8'h5A}, {1'b1, 8'h5A}
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push_line(input logic [7:0] b);
        line_valid = 1'b1; line_data = b;
        step();
        line_valid = 1'b0;
    endtask

    task automatic push_loop(input logic [7:0] b);
        loop_valid = 1'b1; loop_data = b;
        step();
        loop_valid = 1'b0;
    endtask

    task automatic pop_chk(input string req, input logic [7:0] exp);
        rd_req = 1'b1;
        #1;
        chk(req, "rd_data", {24'd0, rd_data}, {24'd0, exp});
        step();
        rd_req = 1'b0;
    endtask

    task automatic tick();
        char_tick = 1'b1;
        step();
        char_tick = 1'b0;
    endtask

    task automatic set_trig(input logic [5:0] v);
        trig_wr = 1'b1; trig_value = v;
        step();
        trig_wr = 1'b0;
    endtask

    initial begin
        #1_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        // Reset state
        chk("R3", "empty after reset", {31'd0, rx_empty}, 32'd1);
        chk("R3", "full after reset", {31'd0, rx_full}, 32'd0);
        chk("R5", "trigger after reset", {31'd0, rx_trigger}, 32'd0);
        chk("R2", "overrun after reset", {31'd0, overrun}, 32'd0);
        chk("R7", "timeout after reset", {31'd0, rx_timeout}, 32'd0);

        // Table walk: order of stored bytes (R1)
        for (int i = 0; i < 10; i++) begin
            if (VEC[i][8]) pop_chk("R1", VEC[i][7:0]);
            else push_line(VEC[i][7:0]);
        end
        chk("R3", "empty after table", {31'd0, rx_empty}, 32'd1);

        // Fill to depth, overrun, wrap (R1, R2, R3, R5)
        for (int i = 0; i < 16; i++) push_line(8'hA0 + 8'(i));
        chk("R3", "full at 16", {31'd0, rx_full}, 32'd1);
        chk("R3", "not empty at 16", {31'd0, rx_empty}, 32'd0);
        chk("R5", "trigger stays low at reset level", {31'd0, rx_trigger}, 32'd0);
        push_line(8'hEE);
        chk("R2", "overrun pulse", {31'd0, overrun}, 32'd1);
        chk("R3", "still full after drop", {31'd0, rx_full}, 32'd1);
        step();
        chk("R2", "overrun one cycle", {31'd0, overrun}, 32'd0);
        pop_chk("R1", 8'hA0);
        chk("R3", "full clears on read", {31'd0, rx_full}, 32'd0);
        for (int i = 1; i < 16; i++) pop_chk("R2", 8'hA0 + 8'(i));
        chk("R2", "dropped byte absent", {31'd0, rx_empty}, 32'd1);

        // Empty read (R4)
        pop_chk("R4", 8'h00);
        chk("R4", "empty kept", {31'd0, rx_empty}, 32'd1);

        // Trigger level (R5)
        set_trig(6'd3);
        push_line(8'h01);
        push_line(8'h02);
        chk("R5", "below level", {31'd0, rx_trigger}, 32'd0);
        push_line(8'h03);
        chk("R5", "at level", {31'd0, rx_trigger}, 32'd1);
        pop_chk("R5", 8'h01);
        chk("R5", "cleared below level", {31'd0, rx_trigger}, 32'd0);
        pop_chk("R5", 8'h02);
        pop_chk("R5", 8'h03);

        // Enable gating (R6)
        rx_disable = 1'b1;
        push_line(8'h77);
        chk("R6", "disabled write ignored", {31'd0, rx_empty}, 32'd1);
        rx_disable = 1'b0;
        push_line(8'h55);
        rx_disable = 1'b1;
        pop_chk("R6", 8'h00);
        rx_disable = 1'b0; rx_enable = 1'b0;
        pop_chk("R6", 8'h00);
        push_line(8'h66);
        rx_enable = 1'b1;
        pop_chk("R6", 8'h55);
        chk("R6", "only enabled byte kept", {31'd0, rx_empty}, 32'd1);

        // Break (R9)
        line_break = 1'b1; line_data = 8'hAA;
        step();
        line_break = 1'b0;
        pop_chk("R9", 8'h00);
        chk("R9", "break consumed", {31'd0, rx_empty}, 32'd1);

        // Channel modes (R10)
        chan_mode = 2'd2;
        push_line(8'h12);
        chk("R10", "loopback ignores line", {31'd0, rx_empty}, 32'd1);
        push_loop(8'h34);
        pop_chk("R10", 8'h34);
        chan_mode = 2'd3;
        push_line(8'h56);
        push_loop(8'h78);
        chk("R10", "remote loopback stores nothing", {31'd0, rx_empty}, 32'd1);
        chan_mode = 2'd1;
        push_loop(8'h9A);
        push_line(8'hBC);
        pop_chk("R10", 8'hBC);
        chk("R10", "echo ignores loop source", {31'd0, rx_empty}, 32'd1);
        chan_mode = 2'd0;

        // Timeout (R7)
        push_line(8'h42);
        for (int i = 0; i < 3; i++) tick();
        chk("R7", "no timeout after 3 ticks", {31'd0, rx_timeout}, 32'd0);
        tick();
        chk("R7", "timeout on 4th tick", {31'd0, rx_timeout}, 32'd1);
        step();
        chk("R7", "timeout one cycle", {31'd0, rx_timeout}, 32'd0);
        for (int i = 0; i < 5; i++) tick();
        chk("R7", "no second timeout", {31'd0, rx_timeout}, 32'd0);
        push_line(8'h43);
        tick(); tick();
        push_line(8'h44);
        for (int i = 0; i < 3; i++) tick();
        chk("R7", "write restarted count", {31'd0, rx_timeout}, 32'd0);
        tick();
        chk("R7", "timeout after restart", {31'd0, rx_timeout}, 32'd1);
        pop_chk("R7", 8'h42);
        pop_chk("R7", 8'h43);
        pop_chk("R7", 8'h44);

        // Clear (R8)
        set_trig(6'd1);
        push_line(8'hC1);
        push_line(8'hC2);
        chk("R8", "trigger before clear", {31'd0, rx_trigger}, 32'd1);
        rx_clear = 1'b1;
        step();
        rx_clear = 1'b0;
        chk("R8", "empty after clear", {31'd0, rx_empty}, 32'd1);
        chk("R8", "full after clear", {31'd0, rx_full}, 32'd0);
        chk("R8", "trigger after clear", {31'd0, rx_trigger}, 32'd0);
        for (int i = 0; i < 4; i++) tick();
        chk("R8", "timer stopped by clear", {31'd0, rx_timeout}, 32'd0);
        pop_chk("R8", 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule